// File: doc/BRIEF.md
# Lowest-Value Index Selector

The block receives a fixed set of unsigned candidates on one flat bus and reports the smallest of them together with the position of the candidate that holds it. The reduction is a balanced tree of two-input minimum cells. Neighbouring candidates meet at the first level, the survivors meet at the next level, and so on until one result remains. Each cell carries the winner's position along with its value, so the index comes out of the same pass as the value and needs no second search.

When several candidates share the smallest value, the reported position is always the lowest of them. In the default build each comparison key holds the value in its upper bits and the position in its lower bits. Two keys are then never equal, so the winner is always defined. A cheaper variant compares the values alone with less-or-equal. That variant also favours the lower position, because in this tree the left input of every cell always comes from lower positions than the right input.

The core is purely combinational. An optional register on the candidate side and an optional register on the result side can be enabled separately for timing. A valid flag travels through the same registers, so it always lines up with the data. The defaults give eight candidates of ten bits and no registers.

Top module: `argmin_tree`

## Requirements
- R1: `min_val_o` equals the smallest of the `N_IN` unsigned candidates, where candidate k occupies bits `[k*DATA_W +: DATA_W]` of `cand_i`.
- R2: The candidate at position `min_idx_o` holds exactly the value reported on `min_val_o`.
- R3: If several candidates share the minimum, `min_idx_o` is the lowest of their positions. If all candidates are equal, including all at the maximum code, the index is 0.
- R4: If only the last candidate (position `N_IN-1`) is strictly smaller than every other, `min_idx_o` is `N_IN-1`.
- R5: With `IN_REG=0` and `OUT_REG=0`, the value, index and `vld_o` follow the inputs in the same cycle, and `vld_o` equals `vld_i`.
- R6: With registers enabled, value, index and `vld_o` appear exactly `IN_REG+OUT_REG` clock cycles after the inputs are presented.
- R7: While `rst_ni` is low, a registered build drives `vld_o`, `min_val_o` and `min_idx_o` to zero, and this takes effect without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional registers |
| rst_ni | input | 1 | Active-low asynchronous reset |
| vld_i | input | 1 | Marks the candidate bus as meaningful |
| cand_i | input | N_IN*DATA_W | Packed candidates; position k at bits [k*DATA_W +: DATA_W] |
| vld_o | output | 1 | Valid flag aligned with the result |
| min_val_o | output | DATA_W | Smallest candidate value |
| min_idx_o | output | $clog2(N_IN) | Position of the smallest candidate, lowest on ties |

## Verification
A wrong cell decision anywhere in the tree shows up in the same result as a value that is larger than some candidate, or as an index whose candidate does not match the reported value. A wrong tie decision shows up as an index above a lower position that holds the same minimum. In registered builds the fault appears exactly `IN_REG+OUT_REG` cycles after the vector that caused it. A misaligned valid flag therefore shows up on the first cycle in which `vld_i` changes.

// File: rtl/argmin_pkg.sv
package argmin_pkg;

   // True when n is a power of two of at least two.
   function automatic bit is_pow2(input int n);
      return (n >= 2) && ((n & (n - 1)) == 0);
   endfunction

   // Number of bits needed to name one of n positions.
   function automatic int idx_width(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

   // Number of tree levels above the leaves.
   function automatic int tree_depth(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/argmin_cell.sv
module argmin_cell #(
   parameter int DATA_W     = 10,
   parameter int IDX_W      = 3,
   parameter bit STABLE_KEY = 1'b1
) (
   input  logic [DATA_W-1:0] a_val_i,
   input  logic [IDX_W-1:0]  a_idx_i,
   input  logic [DATA_W-1:0] b_val_i,
   input  logic [IDX_W-1:0]  b_idx_i,
   output logic [DATA_W-1:0] win_val_o,
   output logic [IDX_W-1:0]  win_idx_o
);

   localparam int KEY_W = DATA_W + IDX_W;

   logic take_a;

   generate
      if (STABLE_KEY) begin : g_key
         // The position sits below the value, so no two keys are ever equal.
         logic [KEY_W-1:0] key_a;
         logic [KEY_W-1:0] key_b;
         always_comb begin
            key_a  = {a_val_i, a_idx_i};
            key_b  = {b_val_i, b_idx_i};
            take_a = (key_a < key_b);
         end
      end else begin : g_le
         // Side a always comes from lower positions, so less-or-equal keeps ties low.
         always_comb begin
            take_a = (a_val_i <= b_val_i);
         end
      end
   endgenerate

   always_comb begin
      if (take_a) begin
         win_val_o = a_val_i;
         win_idx_o = a_idx_i;
      end else begin
         win_val_o = b_val_i;
         win_idx_o = b_idx_i;
      end
   end

endmodule

// File: rtl/argmin_reduce.sv
module argmin_reduce #(
   parameter int N_IN       = 8,
   parameter int DATA_W     = 10,
   parameter bit STABLE_KEY = 1'b1,
   localparam int IDX_W     = argmin_pkg::idx_width(N_IN)
) (
   input  logic [N_IN*DATA_W-1:0] cand_i,
   output logic [DATA_W-1:0]      min_val_o,
   output logic [IDX_W-1:0]       min_idx_o
);

   localparam int LEVELS = argmin_pkg::tree_depth(N_IN);

   generate
      for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
         localparam int CNT = N_IN >> l;
         logic [DATA_W-1:0] val [CNT];
         logic [IDX_W-1:0]  idx [CNT];

         if (l == 0) begin : g_leaf
            for (genvar k = 0; k < CNT; k++) begin : g_in
               assign val[k] = cand_i[k*DATA_W +: DATA_W];
               assign idx[k] = IDX_W'(k);
            end
         end else begin : g_node
            for (genvar p = 0; p < CNT; p++) begin : g_pair
               argmin_cell #(
                  .DATA_W     (DATA_W),
                  .IDX_W      (IDX_W),
                  .STABLE_KEY (STABLE_KEY)
               ) u_cell (
                  .a_val_i   (g_lvl[l-1].val[2*p]),
                  .a_idx_i   (g_lvl[l-1].idx[2*p]),
                  .b_val_i   (g_lvl[l-1].val[2*p+1]),
                  .b_idx_i   (g_lvl[l-1].idx[2*p+1]),
                  .win_val_o (val[p]),
                  .win_idx_o (idx[p])
               );
            end
         end
      end
   endgenerate

   assign min_val_o = g_lvl[LEVELS].val[0];
   assign min_idx_o = g_lvl[LEVELS].idx[0];

endmodule

// File: rtl/argmin_stage.sv
module argmin_stage #(
   parameter int WIDTH  = 8,
   parameter bit ENABLE = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             vld_i,
   input  logic [WIDTH-1:0] d_i,
   output logic             vld_o,
   output logic [WIDTH-1:0] q_o
);

   generate
      if (ENABLE) begin : g_reg
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               vld_o <= 1'b0;
               q_o   <= '0;
            end else begin
               vld_o <= vld_i;
               q_o   <= d_i;
            end
         end
      end else begin : g_wire
         logic unused_clk_rst;
         assign unused_clk_rst = clk_i ^ rst_ni;
         assign vld_o = vld_i;
         assign q_o   = d_i;
      end
   endgenerate

endmodule

// File: rtl/argmin_tree.sv
module argmin_tree #(
   parameter int N_IN       = 8,
   parameter int DATA_W     = 10,
   parameter bit IN_REG     = 1'b0,
   parameter bit OUT_REG    = 1'b0,
   parameter bit STABLE_KEY = 1'b1
) (
   input  logic                                   clk_i,
   input  logic                                   rst_ni,
   input  logic                                   vld_i,
   input  logic [N_IN*DATA_W-1:0]                 cand_i,
   output logic                                   vld_o,
   output logic [DATA_W-1:0]                      min_val_o,
   output logic [argmin_pkg::idx_width(N_IN)-1:0] min_idx_o
);

   localparam int IDX_W = argmin_pkg::idx_width(N_IN);
   localparam int BUS_W = N_IN * DATA_W;
   localparam int RES_W = DATA_W + IDX_W;

   generate
      if (!argmin_pkg::is_pow2(N_IN)) begin : g_bad_n
         $error("argmin_tree: N_IN must be a power of two of at least 2");
      end
      if (DATA_W < 1) begin : g_bad_w
         $error("argmin_tree: DATA_W must be at least 1");
      end
   endgenerate

   logic             core_vld;
   logic [BUS_W-1:0] core_cand;
   logic [DATA_W-1:0] core_val;
   logic [IDX_W-1:0]  core_idx;
   logic [RES_W-1:0]  res_q;

   argmin_stage #(
      .WIDTH  (BUS_W),
      .ENABLE (IN_REG)
   ) u_in_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .vld_i  (vld_i),
      .d_i    (cand_i),
      .vld_o  (core_vld),
      .q_o    (core_cand)
   );

   argmin_reduce #(
      .N_IN       (N_IN),
      .DATA_W     (DATA_W),
      .STABLE_KEY (STABLE_KEY)
   ) u_reduce (
      .cand_i    (core_cand),
      .min_val_o (core_val),
      .min_idx_o (core_idx)
   );

   argmin_stage #(
      .WIDTH  (RES_W),
      .ENABLE (OUT_REG)
   ) u_out_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .vld_i  (core_vld),
      .d_i    ({core_val, core_idx}),
      .vld_o  (vld_o),
      .q_o    (res_q)
   );

   assign min_val_o = res_q[RES_W-1:IDX_W];
   assign min_idx_o = res_q[IDX_W-1:0];

endmodule

// File: rtl/argmin_tree_chk.sv
module argmin_tree_chk #(
   parameter int N_IN    = 8,
   parameter int DATA_W  = 10,
   parameter bit IN_REG  = 1'b0,
   parameter bit OUT_REG = 1'b0
) (
   input logic                                   clk_i,
   input logic                                   rst_ni,
   input logic                                   vld_i,
   input logic [N_IN*DATA_W-1:0]                 cand_i,
   input logic                                   vld_o,
   input logic [DATA_W-1:0]                      min_val_o,
   input logic [argmin_pkg::idx_width(N_IN)-1:0] min_idx_o
);

   localparam int LAT = int'(IN_REG) + int'(OUT_REG);

   // Delay line that lines the inputs up with the result.
   generate
      for (genvar s = 0; s <= LAT; s++) begin : g_dl
         logic                   v;
         logic [N_IN*DATA_W-1:0] c;
         if (s == 0) begin : g_head
            assign v = vld_i;
            assign c = cand_i;
         end else begin : g_tap
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) begin
                  v <= 1'b0;
                  c <= '0;
               end else begin
                  v <= g_dl[s-1].v;
                  c <= g_dl[s-1].c;
               end
            end
         end
      end
   endgenerate

   logic                   vld_t;
   logic [N_IN*DATA_W-1:0] cand_t;
   assign vld_t  = g_dl[LAT].v;
   assign cand_t = g_dl[LAT].c;

   logic              any_smaller;
   logic              lower_tie;
   logic [DATA_W-1:0] picked;

   always_comb begin
      any_smaller = 1'b0;
      lower_tie   = 1'b0;
      picked      = '0;
      for (int i = 0; i < N_IN; i++) begin
         if (cand_t[i*DATA_W +: DATA_W] < min_val_o) any_smaller = 1'b1;
         if ((i < int'(min_idx_o)) && (cand_t[i*DATA_W +: DATA_W] == min_val_o)) lower_tie = 1'b1;
         if (i == int'(min_idx_o)) picked = cand_t[i*DATA_W +: DATA_W];
      end
   end

   assert_min_not_beaten_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld_o |-> !any_smaller);

   assert_index_holds_min_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld_o |-> (picked == min_val_o));

   assert_lowest_on_tie_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld_o |-> !lower_tie);

   assert_valid_latency_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld_o == vld_t);

endmodule

bind argmin_tree argmin_tree_chk #(
   .N_IN    (N_IN),
   .DATA_W  (DATA_W),
   .IN_REG  (IN_REG),
   .OUT_REG (OUT_REG)
) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .vld_i     (vld_i),
   .cand_i    (cand_i),
   .vld_o     (vld_o),
   .min_val_o (min_val_o),
   .min_idx_o (min_idx_o)
);

// File: tb/argmin_tree_bench.sv
module argmin_tree_bench;

   localparam int CLK_PERIOD = 10;
   localparam int N          = 8;
   localparam int W          = 10;
   localparam int IW         = 3;
   localparam int WATCHDOG   = 190000;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           vld = 1'b0;
   logic [N*W-1:0] cand = '0;

   logic          c_vld, p_vld;
   logic [W-1:0]  c_val, p_val;
   logic [IW-1:0] c_idx, p_idx;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   // History of expected results for the two-cycle registered build.
   int hv_val [2];
   int hv_idx [2];
   bit hv_vld [2];
   int primed = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   argmin_tree u_argmin_tree (
      .clk_i (clk), .rst_ni (rst_n), .vld_i (vld), .cand_i (cand),
      .vld_o (c_vld), .min_val_o (c_val), .min_idx_o (c_idx)
   );

   argmin_tree #(.IN_REG(1'b1), .OUT_REG(1'b1)) u_argmin_tree_piped (
      .clk_i (clk), .rst_ni (rst_n), .vld_i (vld), .cand_i (cand),
      .vld_o (p_vld), .min_val_o (p_val), .min_idx_o (p_idx)
   );

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Reference: scan from position 0 upward with strict less-than.
   task automatic ref_scan(input logic [N*W-1:0] v, output int mv, output int mi);
      mv = int'(v[W-1:0]);
      mi = 0;
      for (int i = 1; i < N; i++) begin
         if (int'(v[i*W +: W]) < mv) begin
            mv = int'(v[i*W +: W]);
            mi = i;
         end
      end
   endtask

   task automatic apply(input logic [N*W-1:0] v, input bit vi, input string idx_tag);
      int ev, ei;
      ref_scan(v, ev, ei);
      @(posedge clk);
      #1;
      cand = v;
      vld  = vi;
      #3;
      chk("R1", int'(c_val), ev);
      chk(idx_tag, int'(c_idx), ei);
      chk("R5", int'(c_vld), int'(vi));
      if (primed >= 2) begin
         chk("R6", int'(p_val), hv_val[1]);
         chk("R6", int'(p_idx), hv_idx[1]);
         chk("R6", int'(p_vld), int'(hv_vld[1]));
      end
      hv_val[1] = hv_val[0]; hv_idx[1] = hv_idx[0]; hv_vld[1] = hv_vld[0];
      hv_val[0] = ev;        hv_idx[0] = ei;        hv_vld[0] = vi;
      primed++;
   endtask

   function automatic logic [W-1:0] level(input int d);
      case (d)
         0:       return W'(0);
         1:       return W'(1);
         2:       return W'(512);
         default: return W'(1023);
      endcase
   endfunction

   function automatic logic [N*W-1:0] fill(input int x);
      logic [N*W-1:0] r;
      for (int i = 0; i < N; i++) r[i*W +: W] = W'(x);
      return r;
   endfunction

   initial begin
      logic [N*W-1:0] v;
      int n;
      n = 0;
      cand  = fill(77);
      vld   = 1'b1;
      rst_n = 1'b0;
      #(2*CLK_PERIOD + 2);
      // R7: registered outputs held at zero during reset.
      chk("R7", int'(p_vld), 0);
      chk("R7", int'(p_val), 0);
      chk("R7", int'(p_idx), 0);
      @(posedge clk);
      #1;
      rst_n = 1'b1;

      // R3: all equal, including the all-ones code, gives position 0.
      apply(fill(1023), 1'b1, "R3");
      apply(fill(0), 1'b1, "R3");
      apply(fill(300), 1'b0, "R3");

      // R4: only the last candidate is smaller.
      v = fill(600);
      v[(N-1)*W +: W] = W'(599);
      apply(v, 1'b1, "R4");
      v = fill(1023);
      v[(N-1)*W +: W] = W'(1022);
      apply(v, 1'b1, "R4");

      // R3: duplicate minima at every pair of positions.
      for (int i = 0; i < N; i++) begin
         for (int j = i + 1; j < N; j++) begin
            v = fill(1023);
            v[i*W +: W] = W'(i*7 + j + 3);
            v[j*W +: W] = W'(i*7 + j + 3);
            apply(v, (i + j) % 2 == 0, "R3");
         end
      end

      // Exhaustive sweep over four levels per candidate (ties are frequent).
      for (int code = 0; code < (1 << (2*N)); code++) begin
         for (int i = 0; i < N; i++) v[i*W +: W] = level((code >> (2*i)) & 3);
         apply(v, (code % 3) != 0, "R2");
      end

      // Random full-range vectors.
      for (int r = 0; r < 2000; r++) begin
         for (int i = 0; i < N; i++) v[i*W +: W] = W'($urandom_range(1023));
         apply(v, r[0], "R2");
         n++;
      end

      // R7: asynchronous reset clears the registered build at once.
      @(posedge clk);
      #1;
      vld  = 1'b1;
      cand = fill(5);
      @(posedge clk);
      @(posedge clk);
      #1;
      rst_n = 1'b0;
      #1;
      chk("R7", int'(p_vld), 0);
      chk("R7", int'(p_val), 0);
      chk("R7", int'(p_idx), 0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL R6 watchdog act=running exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule